// File: doc/BRIEF.md
# Bit-Serial Bitonic Packet Sorter

This block reorders eight bit-serial packet streams so that they arrive at a self-routing banyan fabric in ascending destination order, with idle lanes grouped at the high-numbered end. Every lane carries one bit per clock. A packet starts with one activity bit (0 = carries a packet, 1 = idle). Then come the destination address bits, most significant first, and then the payload. A single start strobe, common to all lanes, marks the cycle that carries the activity bit.

The network is a bitonic merge-sort arrangement of two-port compare-exchange cells. It is built as a chain of registered columns: three column groups merge runs of 2, 4 and 8 lanes, giving six columns for eight lanes. Each cell begins a packet in the straight-through state. It watches its two header streams bit by bit and flips to the swapped state at the first header bit where the two differ in the wrong direction for that cell. It then keeps that state until the next start strobe, so the payload follows its header to the same output lane.

Top module: `bsort_net`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every output lane and the output start strobe read 0.
- R2: The output start strobe, and each packet's first bit, appear exactly NUM_STAGES (6 for eight lanes) clock cycles after the matching input cycle. Every packet sent leaves the block.
- R3: In each output packet set, lanes carrying active packets (activity bit 0) show their 4-bit headers {activity, address} in non-decreasing order from lane 0 upward.
- R4: Idle packets (activity bit 1) leave on the highest-numbered lanes, above every active packet, ordered among themselves by their address bits.
- R5: Each packet leaves intact on a single lane: all header and payload bits of one input packet appear together on one output lane, and no packet is lost or duplicated.
- R6: The compare decision covers every header bit, including the least significant address bit. Packets whose headers differ only in that bit still come out ordered.
- R7: A start strobe on the cycle right after a packet's last bit re-arms every cell, so back-to-back packet sets are each sorted on their own.
- R8: Packets with identical headers are all delivered, on adjacent output lanes.
- R9: On every clock cycle, the number of 1 bits across the output lanes equals the number across the input lanes NUM_STAGES cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start_i | input | 1 | High on the cycle that carries the activity bit of all lanes |
| lanes_i | input | LANES | One serial bit per input lane |
| pkt_start_o | output | 1 | Start strobe delayed to match the sorted output |
| lanes_o | output | LANES | One serial bit per output lane, sorted order |

## Verification
The bench targets header pairs that differ only in the last address bit. A decision window cut one bit short would leave such pairs unswapped, and they would come out out of order. Duplicate headers with different payloads check that a cell never splits a packet or drops a copy; a cell that kept deciding on payload bits, or that switched state mid-packet, would scramble payload bits between lanes. Back-to-back sets with no gap, and sets that are fully or partly idle, catch a cell that is not re-armed by the strobe or that sorts the activity bit the wrong way, which would push real packets behind idle ones.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    // Direction of one compare-exchange cell: UP puts the smaller stream on the upper port.
    typedef enum logic {
        SORT_UP   = 1'b0,
        SORT_DOWN = 1'b1
    } sort_dir_e;

    // Per-packet state of a cell.
    typedef struct packed {
        logic settled;
        logic crossed;
    } xbar_state_t;

    function automatic int num_stages(input int log_n);
        return (log_n * (log_n + 1)) / 2;
    endfunction

    // Distance between paired lanes in column s.
    function automatic int stage_span(input int log_n, input int s);
        int idx;
        int res;
        idx = 0;
        res = 1;
        for (int kl = 1; kl <= log_n; kl++) begin
            for (int jl = kl - 1; jl >= 0; jl--) begin
                if (idx == s) res = 1 << jl;
                idx++;
            end
        end
        return res;
    endfunction

    // Size of the merge block handled in column s.
    function automatic int stage_block(input int log_n, input int s);
        int idx;
        int res;
        idx = 0;
        res = 2;
        for (int kl = 1; kl <= log_n; kl++) begin
            for (int jl = kl - 1; jl >= 0; jl--) begin
                if (idx == s) res = 1 << kl;
                idx++;
            end
        end
        return res;
    endfunction

    function automatic sort_dir_e pair_dir(input int lane, input int blk);
        return ((lane & blk) == 0) ? SORT_UP : SORT_DOWN;
    endfunction

endpackage

// File: rtl/bsort_cmp.sv
module bsort_cmp
    import bsort_pkg::*;
#(
    parameter sort_dir_e DIR = SORT_UP
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic window,
    input  logic up_i,
    input  logic dn_i,
    output logic up_o,
    output logic dn_o
);

    xbar_state_t st_q;
    xbar_state_t base;
    xbar_state_t nxt;

    always_comb begin
        base = restart ? '0 : st_q;
        nxt  = base;
        if (window && !base.settled && (up_i != dn_i)) begin
            nxt.settled = 1'b1;
            // UP cell swaps when the upper stream is larger, DOWN when it is smaller
            nxt.crossed = (DIR == SORT_UP) ? up_i : dn_i;
        end
    end

    assign up_o = nxt.crossed ? dn_i : up_i;
    assign dn_o = nxt.crossed ? up_i : dn_i;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= nxt;
    end

endmodule

// File: rtl/bsort_stage.sv
module bsort_stage
    import bsort_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int HDR_LEN = 4,
    parameter int SPAN    = 1,
    parameter int BLK     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sop_i,
    input  logic [LANES-1:0] lane_i,
    output logic             sop_o,
    output logic [LANES-1:0] lane_o
);

    localparam int CW = $clog2(HDR_LEN + 1);
    localparam logic [CW-1:0] HDR_CNT = CW'(HDR_LEN);

    logic [CW-1:0]    bit_cnt;
    logic             window;
    logic             mix [LANES];
    logic [LANES-1:0] mix_v;

    // Bits seen since the strobe; saturates at the header length.
    always_ff @(posedge clk) begin
        if (rst)                   bit_cnt <= HDR_CNT;
        else if (sop_i)            bit_cnt <= CW'(1);
        else if (bit_cnt < HDR_CNT) bit_cnt <= bit_cnt + 1'b1;
    end

    assign window = sop_i || (bit_cnt < HDR_CNT);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if ((i & SPAN) == 0) begin : g_pair
            bsort_cmp #(.DIR(pair_dir(i, BLK))) u_cmp (
                .clk    (clk),
                .rst    (rst),
                .restart(sop_i),
                .window (window),
                .up_i   (lane_i[i]),
                .dn_i   (lane_i[i+SPAN]),
                .up_o   (mix[i]),
                .dn_o   (mix[i+SPAN])
            );
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) mix_v[i] = mix[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sop_o  <= 1'b0;
            lane_o <= '0;
        end else begin
            sop_o  <= sop_i;
            lane_o <= mix_v;
        end
    end

endmodule

// File: rtl/bsort_net.sv
module bsort_net
    import bsort_pkg::*;
#(
    parameter  int LOG_LANES  = 3,
    parameter  int ADDR_W     = 3,
    localparam int LANES      = 1 << LOG_LANES,
    localparam int NUM_STAGES = num_stages(LOG_LANES),
    localparam int HDR_LEN    = 1 + ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_start_i,
    input  logic [LANES-1:0] lanes_i,
    output logic             pkt_start_o,
    output logic [LANES-1:0] lanes_o
);

    logic [LANES-1:0] bus     [NUM_STAGES+1];
    logic             sop_bus [NUM_STAGES+1];

    assign bus[0]     = lanes_i;
    assign sop_bus[0] = pkt_start_i;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_col
        bsort_stage #(
            .LANES  (LANES),
            .HDR_LEN(HDR_LEN),
            .SPAN   (stage_span(LOG_LANES, s)),
            .BLK    (stage_block(LOG_LANES, s))
        ) u_col (
            .clk   (clk),
            .rst   (rst),
            .sop_i (sop_bus[s]),
            .lane_i(bus[s]),
            .sop_o (sop_bus[s+1]),
            .lane_o(bus[s+1])
        );
    end

    assign lanes_o     = bus[NUM_STAGES];
    assign pkt_start_o = sop_bus[NUM_STAGES];

endmodule

// File: rtl/bsort_net_chk.sv
module bsort_net_chk #(
    parameter int LANES      = 8,
    parameter int NUM_STAGES = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             pkt_start_i,
    input logic [LANES-1:0] lanes_i,
    input logic             pkt_start_o,
    input logic [LANES-1:0] lanes_o
);

    localparam int CNTW = $clog2(LANES + 1);
    localparam int LAST = NUM_STAGES - 1;

    logic [NUM_STAGES-1:0] vld;
    logic [NUM_STAGES-1:0] sop_sh;
    logic [CNTW-1:0]       ones_sh [NUM_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            sop_sh <= '0;
            for (int k = 0; k < NUM_STAGES; k++) ones_sh[k] <= '0;
        end else begin
            vld[0]     <= 1'b1;
            sop_sh[0]  <= pkt_start_i;
            ones_sh[0] <= CNTW'($countones(lanes_i));
            for (int k = 1; k < NUM_STAGES; k++) begin
                vld[k]     <= vld[k-1];
                sop_sh[k]  <= sop_sh[k-1];
                ones_sh[k] <= ones_sh[k-1];
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lanes_o == '0 && !pkt_start_o));

    // R2
    start_latency_chk: assert property (@(posedge clk) disable iff (rst)
        vld[LAST] |-> (pkt_start_o == sop_sh[LAST]));

    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_start_o |-> (((~lanes_o) & ((~lanes_o) + 1'b1)) == '0));

    // R9
    ones_kept_chk: assert property (@(posedge clk) disable iff (rst)
        vld[LAST] |-> (CNTW'($countones(lanes_o)) == ones_sh[LAST]));

endmodule

bind bsort_net bsort_net_chk #(
    .LANES     (LANES),
    .NUM_STAGES(NUM_STAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pkt_start_i(pkt_start_i),
    .lanes_i    (lanes_i),
    .pkt_start_o(pkt_start_o),
    .lanes_o    (lanes_o)
);

// File: tb/bsort_net_test.sv
`timescale 1ns/1ps
module bsort_net_test;

    localparam int NL   = 8;
    localparam int PLEN = 12;
    localparam int LAT  = 6;

    typedef struct packed {
        logic [NL*PLEN-1:0] pkts;
        logic [4*NL-1:0]    skeys;
        logic [31:0]        start;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_start_i = 1'b0;
    logic [NL-1:0] lanes_i = '0;
    logic          pkt_start_o;
    logic [NL-1:0] lanes_o;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];

    bsort_net uut (
        .clk        (clk),
        .rst        (rst),
        .pkt_start_i(pkt_start_i),
        .lanes_i    (lanes_i),
        .pkt_start_o(pkt_start_o),
        .lanes_o    (lanes_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(input logic [3:0] k0, k1, k2, k3, k4, k5, k6, k7);
        return {k7, k6, k5, k4, k3, k2, k1, k0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: build one packet per lane, push the expectation, stream the bits.
    task automatic send_set(input logic [31:0] keys, input logic [7:0] seed, input int gap);
        exp_t        it;
        logic [3:0]  srt [NL];
        logic [3:0]  tmp;
        logic [3:0]  key;
        logic [7:0]  pay;
        for (int l = 0; l < NL; l++) begin
            key = keys[4*l +: 4];
            pay = seed ^ {key, ~key} ^ 8'(l * 37);
            it.pkts[PLEN*l +: PLEN] = {key, pay};
            srt[l] = key;
        end
        for (int a = 0; a < NL; a++)
            for (int b = 0; b < NL - 1 - a; b++)
                if (srt[b] > srt[b+1]) begin
                    tmp = srt[b]; srt[b] = srt[b+1]; srt[b+1] = tmp;
                end
        for (int l = 0; l < NL; l++) it.skeys[4*l +: 4] = srt[l];
        for (int b = 0; b < PLEN; b++) begin
            @(negedge clk);
            pkt_start_i = (b == 0);
            for (int l = 0; l < NL; l++) lanes_i[l] = it.pkts[PLEN*l + PLEN - 1 - b];
            if (b == 0) begin
                it.start = 32'(cyc);
                q.push_back(it);
            end
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            pkt_start_i = 1'b0;
            lanes_i     = '0;
        end
    endtask

    // Monitor: capture one sorted set and compare with the oldest expectation.
    initial begin
        logic [NL*PLEN-1:0] got;
        logic [NL-1:0]      used;
        logic [PLEN-1:0]    lp;
        logic [3:0]         ek;
        exp_t               it;
        bit                 found;
        int                 t0;
        forever begin
            @(negedge clk);
            if (!rst && pkt_start_o) begin
                t0 = cyc;
                for (int b = 0; b < PLEN; b++) begin
                    if (b > 0) @(negedge clk);
                    for (int l = 0; l < NL; l++) got[PLEN*l + PLEN - 1 - b] = lanes_o[l];
                end
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected set", t0, 0);
                end else begin
                    it = q.pop_front();
                    check(t0 - int'(it.start) == LAT, "R2 latency", t0 - int'(it.start), LAT);
                    used = '0;
                    for (int l = 0; l < NL; l++) begin
                        lp = got[PLEN*l +: PLEN];
                        ek = it.skeys[4*l +: 4];
                        // R3 active order, R4 idle placement, R6/R7/R8 via chosen sets
                        check(lp[11:8] == ek, ek[3] ? "R4 header lane" : "R3 header lane",
                              int'(lp[11:8]), int'(ek));
                        found = 1'b0;
                        for (int j = 0; j < NL; j++)
                            if (!found && !used[j] && it.pkts[PLEN*j +: PLEN] == lp) begin
                                found   = 1'b1;
                                used[j] = 1'b1;
                            end
                        check(found, "R5 packet intact", int'(lp), int'(ek));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(pkt_start_o == 1'b0, "R1 start strobe", int'(pkt_start_o), 0);
        check(lanes_o == '0, "R1 lanes", int'(lanes_o), 0);
        repeat (3) @(negedge clk);

        // R3 all active, reversed addresses
        send_set(mk(4'h7, 4'h6, 4'h5, 4'h4, 4'h3, 4'h2, 4'h1, 4'h0), 8'h3C, 3);
        // R3 scrambled addresses
        send_set(mk(4'h3, 4'h6, 4'h0, 4'h5, 4'h1, 4'h7, 4'h2, 4'h4), 8'hA5, 2);
        // R4 idle lanes interleaved with active ones
        send_set(mk(4'hA, 4'h2, 4'hF, 4'h5, 4'h8, 4'h0, 4'hC, 4'h7), 8'h5A, 2);
        // R4 every lane idle
        send_set(mk(4'hF, 4'h8, 4'hB, 4'h9, 4'hE, 4'hA, 4'hD, 4'hC), 8'h0F, 2);
        // R8 duplicate headers
        send_set(mk(4'h5, 4'h5, 4'h1, 4'h5, 4'h1, 4'h9, 4'h9, 4'h3), 8'hC3, 2);
        // R6 neighbours differ only in the last address bit
        send_set(mk(4'h7, 4'h6, 4'h1, 4'h0, 4'h3, 4'h2, 4'h5, 4'h4), 8'hF0, 2);
        // R7 back-to-back sets with no gap
        send_set(mk(4'h2, 4'h9, 4'h4, 4'h0, 4'hE, 4'h6, 4'h1, 4'h3), 8'h96, 0);
        send_set(mk(4'h1, 4'h0, 4'h7, 4'h8, 4'h3, 4'h3, 4'h6, 4'hB), 8'h69, 0);
        send_set(mk(4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7), 8'hFF, 4);

        repeat (LAT + PLEN + 4) @(negedge clk);
        // R2 every set delivered
        check(q.size() == 0, "R2 all delivered", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule